// File: doc/BRIEF.md
# Waveform Select, Gain and Offset Datapath

This block is the last digital stage in front of a 12-bit DAC. Each clock it takes one of six candidate samples: a sawtooth, a pseudorandom word, a DC level, a gated sine, a RAM sample, or the gated sine scaled by the RAM sample. It then multiplies the chosen sample by a signed fractional gain and adds a signed offset. The result is clamped to the signed 12-bit range, so large values do not wrap around.

The source waveforms are generated elsewhere and arrive as signed 12-bit words. A burst-enable input gates the sine during pulse windows. Every input, including the select code, gain, offset and burst enable, is captured together. The output follows two clock edges later.

Top module: `wavpath_top`

## Requirements
- R1: Select codes pass a source through unchanged: 0 sawtooth, 1 pseudorandom, 2 DC level, 4 RAM sample; code 3 passes the sine while burst enable is high.
- R2: Code 5 gives the modulated sine: the product of sine and RAM sample, arithmetically shifted right by 11 (rounded toward minus infinity), then clamped to [-2048, 2047].
- R3: While burst enable is low, codes 3 and 5 give a zero pre-gain sample. Codes 0, 1, 2 and 4 are not affected by burst enable.
- R4: Codes 6 and 7 give a zero pre-gain sample.
- R5: Gain is two's complement Q2.10: the pre-gain sample times the gain is shifted right arithmetically by 10. A gain of 0x400 is unity and 0x000 gives zero.
- R6: The signed 12-bit offset is added after the gain stage.
- R7: The final sum is clamped to [-2048, 2047] and never wraps.
- R8: The output reflects all inputs sampled exactly two rising clock edges earlier. This includes gain and offset.
- R9: While the active-low reset is asserted, the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Source select code |
| burst_en | input | 1 | Pulse window enable for the sine-based sources |
| saw_in | input | 12 | Sawtooth sample, signed |
| noise_in | input | 12 | Pseudorandom sample, signed |
| level_in | input | 12 | DC level, signed |
| tone_in | input | 12 | Phase-shifted sine sample, signed |
| table_in | input | 12 | RAM sample, signed |
| gain_in | input | 12 | Gain, signed Q2.10 |
| offset_in | input | 12 | Offset, signed |
| dac_out | output | 12 | Sample to the DAC, signed |

## Verification
The hardest cases come from saturation in the modulation product. Only full-scale negative sine times full-scale negative RAM overflows the shifted product. At the output, positive and negative clamping depend jointly on sample, gain and offset. The stimulus therefore sweeps every select code against both burst states. It crosses source values that include both rails with each other, then crosses rail-valued levels with extreme gains and offsets. A streaming run changes the level and gain on every cycle to pin the two-edge alignment.

// File: rtl/wavpath_pkg.sv
package wavpath_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_SAW     = 3'd0,
        SRC_NOISE   = 3'd1,
        SRC_LEVEL   = 3'd2,
        SRC_TONE    = 3'd3,
        SRC_TABLE   = 3'd4,
        SRC_TONE_AM = 3'd5
    } src_sel_e;

endpackage

// File: rtl/wavpath_select.sv
module wavpath_select
    import wavpath_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic                 burst_en,
    input  logic signed [DW-1:0] saw_s,
    input  logic signed [DW-1:0] noise_s,
    input  logic signed [DW-1:0] level_s,
    input  logic signed [DW-1:0] tone_s,
    input  logic signed [DW-1:0] table_s,
    output logic signed [DW-1:0] pick
);

    localparam int MW = 2 * DW;
    localparam logic signed [MW-1:0] HI = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [MW-1:0] LO = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [MW-1:0] prod;
    logic signed [MW-1:0] shifted;
    logic signed [DW-1:0] am;
    logic signed [DW-1:0] tone_g;

    always_comb begin
        prod    = tone_s * table_s;
        shifted = prod >>> (DW - 1);
        if (shifted > HI) begin
            am = HI[DW-1:0];
        end else if (shifted < LO) begin
            am = LO[DW-1:0];
        end else begin
            am = shifted[DW-1:0];
        end
        tone_g = burst_en ? tone_s : '0;
    end

    always_comb begin
        case (src_sel_e'(sel))
            SRC_SAW:     pick = saw_s;
            SRC_NOISE:   pick = noise_s;
            SRC_LEVEL:   pick = level_s;
            SRC_TONE:    pick = tone_g;
            SRC_TABLE:   pick = table_s;
            SRC_TONE_AM: pick = burst_en ? am : '0;
            default:     pick = '0;
        endcase
    end

endmodule

// File: rtl/wavpath_scale.sv
module wavpath_scale #(
    parameter int DW   = 12,
    parameter int GW   = 12,
    parameter int FRAC = 10
) (
    input  logic signed [DW-1:0] pick,
    input  logic signed [GW-1:0] gain,
    input  logic signed [DW-1:0] offset,
    output logic signed [DW-1:0] result
);

    localparam int PW = DW + GW;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [SW-1:0] sum;

    always_comb begin
        prod   = pick * gain;
        scaled = prod >>> FRAC;
        sum    = {scaled[PW-1], scaled} + {{(SW-DW){offset[DW-1]}}, offset};
        if (sum > HI) begin
            result = HI[DW-1:0];
        end else if (sum < LO) begin
            result = LO[DW-1:0];
        end else begin
            result = sum[DW-1:0];
        end
    end

endmodule

// File: rtl/wavpath_top.sv
module wavpath_top
    import wavpath_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 12,
    parameter int FRAC = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 burst_en,
    input  logic signed [DW-1:0] saw_in,
    input  logic signed [DW-1:0] noise_in,
    input  logic signed [DW-1:0] level_in,
    input  logic signed [DW-1:0] tone_in,
    input  logic signed [DW-1:0] table_in,
    input  logic signed [GW-1:0] gain_in,
    input  logic signed [DW-1:0] offset_in,
    output logic signed [DW-1:0] dac_out
);

    localparam logic signed [GW-1:0] UNITY = GW'(1 << FRAC);

    typedef struct packed {
        logic signed [DW-1:0] pick;
        logic signed [GW-1:0] gain;
        logic signed [DW-1:0] offset;
        logic signed [DW-1:0] out;
    } pipe_t;

    pipe_t st_d, st_q;
    logic signed [DW-1:0] pick_w;
    logic signed [DW-1:0] scaled_w;

    wavpath_select #(.DW(DW)) u_select (
        .sel      (sel),
        .burst_en (burst_en),
        .saw_s    (saw_in),
        .noise_s  (noise_in),
        .level_s  (level_in),
        .tone_s   (tone_in),
        .table_s  (table_in),
        .pick     (pick_w)
    );

    wavpath_scale #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scale (
        .pick   (st_q.pick),
        .gain   (st_q.gain),
        .offset (st_q.offset),
        .result (scaled_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pick   = pick_w;
        st_d.gain   = gain_in;
        st_d.offset = offset_in;
        st_d.out    = scaled_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_out = st_q.out;

    a_r1_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_LEVEL) |=> (st_q.pick == $past(level_in)));

    a_r3_burst_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (((sel == SRC_TONE) || (sel == SRC_TONE_AM)) && !burst_en) |=> (st_q.pick == '0));

    a_r4_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > SRC_TONE_AM) |=> (st_q.pick == '0));

    a_r5_unity_gain: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.gain == UNITY) && (st_q.offset == '0)) |=> (dac_out == $past(st_q.pick)));

    a_r8_two_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SRC_LEVEL) && (gain_in == UNITY) && (offset_in == '0))
        |=> ##1 (dac_out == $past(level_in, 2)));

endmodule

// File: tb/wavpath_top_test.sv
module wavpath_top_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  sel = '0;
    logic        burst_en = 1'b0;
    logic [11:0] saw_in = '0, noise_in = '0, level_in = '0, tone_in = '0, table_in = '0;
    logic [11:0] gain_in = '0, offset_in = '0;
    logic [11:0] dac_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wavpath_top uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .burst_en(burst_en),
        .saw_in(saw_in), .noise_in(noise_in), .level_in(level_in),
        .tone_in(tone_in), .table_in(table_in), .gain_in(gain_in),
        .offset_in(offset_in), .dac_out(dac_out)
    );

    int vals[7] = '{-2048, -1500, -1, 0, 1, 700, 2047};
    int gains[8] = '{-2048, -1024, -1, 0, 1, 512, 1024, 2047};
    int offs[5] = '{-2048, -300, 0, 5, 2047};

    function automatic int sat12(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int s12(logic [11:0] x);
        return int'($signed(x));
    endfunction

    function automatic int model(int s, bit b, int saw, int noi, int lev, int ton,
                                 int tab, int g, int o);
        int p;
        case (s)
            0: p = saw;
            1: p = noi;
            2: p = lev;
            3: p = b ? ton : 0;
            4: p = tab;
            5: p = b ? sat12((ton * tab) >>> 11) : 0;
            default: p = 0;
        endcase
        return sat12(((p * g) >>> 10) + o);
    endfunction

    task automatic check(string req, int expv);
        compared++;
        if (s12(dac_out) != expv) begin
            mismatched++;
            $display("FAIL %s: dac_out=%0d expected=%0d (sel=%0d burst=%0b gain=%0d off=%0d)",
                     req, s12(dac_out), expv, sel, burst_en, s12(gain_in), s12(offset_in));
        end
    endtask

    task automatic apply_check(string req, int s, bit b, int saw, int noi, int lev,
                               int ton, int tab, int g, int o);
        @(negedge clk);
        sel = 3'(s); burst_en = b;
        saw_in = 12'(saw); noise_in = 12'(noi); level_in = 12'(lev);
        tone_in = 12'(ton); table_in = 12'(tab);
        gain_in = 12'(g); offset_in = 12'(o);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, model(s, b, saw, noi, lev, ton, tab, g, o));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run incomplete, actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int lv[12];
        int gv[12];
        repeat (3) @(negedge clk);
        check("R9 reset", 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: every code, both burst states, crossed source values
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 7; i++) begin
                    for (int j = 0; j < 7; j++) begin
                        string tag;
                        if (s == 5) tag = "R2";
                        else if (s > 5) tag = "R4";
                        else if (b == 0 && s == 3) tag = "R3";
                        else tag = "R1";
                        apply_check(tag, s, b[0], vals[i], vals[j], vals[(i + j) % 7],
                                    vals[i], vals[j], 1024, 0);
                    end
                end
            end
        end

        // R5 R6 R7: gain and offset sweep on the level source
        for (int i = 0; i < 7; i++)
            for (int g = 0; g < 8; g++)
                for (int o = 0; o < 5; o++)
                    apply_check("R5_R6_R7", 2, 1'b0, 0, 0, vals[i], 0, 0, gains[g], offs[o]);

        // R2 R7: modulated sine through extreme gains
        for (int i = 0; i < 7; i++)
            for (int g = 0; g < 8; g++)
                apply_check("R2_R7", 5, 1'b1, 0, 0, 0, vals[i], vals[6 - i], gains[g], 0);

        // R8: level and gain change every cycle
        for (int k = 0; k < 12; k++) begin
            lv[k] = k * 337 - 1900;
            gv[k] = (k % 3 == 0) ? 1024 : ((k % 3 == 1) ? 512 : -1024);
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k >= 2) check("R8", model(2, 1'b0, 0, 0, lv[k-2], 0, 0, gv[k-2], 0));
            sel = 3'd2; offset_in = '0;
            level_in = 12'(lv[k]); gain_in = 12'(gv[k]);
        end

        // R9: asynchronous reset mid-run clears the output
        apply_check("R1", 2, 1'b0, 0, 0, 900, 0, 0, 1024, 0);
        #2 rst_n = 1'b0;
        #1 check("R9 async", 0);
        @(negedge clk);
        check("R9 held", 0);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule